// File: doc/BRIEF.md
# Torus Direction Header Builder

This block sits between a local processor and its router in a 4x4 bidirectional torus. The processor hands over a packet whose header names only the destination column and row. The block compares each destination coordinate with the node's own coordinate and picks the shorter way round each ring. It then sends out a packet whose header carries the destination plus one direction code per axis, followed by the untouched payload.

The node's own coordinate is written once after reset through a load strobe. Packets enter and leave on valid/ready handshakes. A single output register holds each result. A new packet can be taken in the same cycle that the held one is consumed, so one packet per cycle can pass.

Top module: `torus_hdr_builder`

## Requirements
- R1: After reset `outValid` is 0, and `inReady` stays 0 until a node location has been loaded, so no packet is accepted before then.
- R2: A `locLoad` pulse while no location is stored captures `locIn`, with X in bits [3:2] and Y in bits [1:0]. `inReady` is 1 in the following cycle when no output is held.
- R3: Any `locLoad` after the first capture, until the next reset, has no effect on the directions computed.
- R4: The X direction code, in `outHdr[3:2]`, is 01 (towards increasing X) when destination X minus local X is 1, 2 or -3. It is 10 (towards decreasing X) when that difference is -1, -2, 3 or 0.
- R5: The Y direction code, in `outHdr[1:0]`, follows the same rule on the Y difference: 01 (up) for 1, 2 or -3, and 10 (down) for -1, -2, 3 or 0.
- R6: `outHdr[7:4]` repeats the accepted `inDest` unchanged, with X in [7:6] and Y in [5:4].
- R7: `outPayload` equals the payload of the accepted packet bit for bit.
- R8: A packet accepted in cycle k (`inValid` and `inReady` both 1 at an edge) is presented with `outValid` = 1 from the following cycle.
- R9: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and `outHdr` and `outPayload` hold their values.
- R10: When the held packet is consumed and a new one is offered in the same cycle, the new one is accepted; `outValid` returns to 0 only when a packet is consumed and none is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| locLoad | input | 1 | Strobe that captures the node location |
| locIn | input | 4 | Node location {X, Y} |
| inValid | input | 1 | Incoming packet valid |
| inReady | output | 1 | Block can take an incoming packet |
| inDest | input | 4 | Destination {X, Y} of the incoming packet |
| inPayload | input | 32 | Incoming payload |
| outValid | output | 1 | Outgoing packet valid |
| outReady | input | 1 | Router side takes the outgoing packet |
| outHdr | output | 8 | {destination X, destination Y, X direction, Y direction} |
| outPayload | output | 32 | Outgoing payload |

## Verification
The registered results (header, payload and `outValid`) change at the first rising edge after the accepting edge. `inReady` is combinational from the held state and `outReady`, so it can change within the same cycle. The bench drives inputs on the falling edge. It updates its reference state on the rising edge and compares every output one nanosecond after the falling edge. At that point inputs have settled and the registers hold the values due for that cycle. The full sweep reloads the node location after a reset for each of the 16 locations and sends all 16 destinations back to back.

// File: rtl/torus_hdr_pkg.sv
package torus_hdr_pkg;

  // Two-bit travel code per axis; 01 = increasing coordinate, 10 = decreasing
  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_POS  = 2'b01,
    DIR_NEG  = 2'b10,
    DIR_BAD  = 2'b11
  } dirCode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capLoc;   // store node location
    logic loadOut;  // load output packet register
  } ctlStrobe_t;

endpackage

// File: rtl/torus_axis_dir.sv
module torus_axis_dir
  import torus_hdr_pkg::*;
#(
  parameter int COORD_W = 2,
  localparam int RING = 1 << COORD_W
) (
  input  logic [COORD_W-1:0] dst,
  input  logic [COORD_W-1:0] loc,
  output dirCode_t           dir
);

  localparam logic signed [COORD_W:0] HALF_S = (COORD_W+1)'(RING / 2);
  localparam logic signed [COORD_W:0] ZERO_S = '0;

  logic signed [COORD_W:0] diff;
  logic                    isPos;

  // Signed difference spans -(RING-1)..(RING-1) without wrap
  assign diff  = $signed({1'b0, dst}) - $signed({1'b0, loc});
  // Forward for 1..HALF, or for a large negative step that wraps short
  assign isPos = ((diff > ZERO_S) && (diff <= HALF_S)) || (diff < -HALF_S);
  assign dir   = isPos ? DIR_POS : DIR_NEG;

endmodule

// File: rtl/torus_hdr_dp.sv
module torus_hdr_dp
  import torus_hdr_pkg::*;
#(
  parameter int COORD_W   = 2,
  parameter int PAYLOAD_W = 32,
  localparam int LOC_W = 2 * COORD_W,
  localparam int HDR_W = LOC_W + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctlStrobe_t           strb,
  input  logic [LOC_W-1:0]     locIn,
  input  logic [LOC_W-1:0]     inDest,
  input  logic [PAYLOAD_W-1:0] inPayload,
  output logic [HDR_W-1:0]     outHdr,
  output logic [PAYLOAD_W-1:0] outPayload
);

  logic [LOC_W-1:0] locReg;
  dirCode_t         axisDir [2];
  logic [HDR_W-1:0] nextHdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locReg <= '0;
    end else if (strb.capLoc) begin
      locReg <= locIn;
    end
  end

  // axis 1 = X (upper field), axis 0 = Y (lower field)
  for (genvar g = 0; g < 2; g++) begin : g_axis
    torus_axis_dir #(.COORD_W(COORD_W)) u_axis (
      .dst (inDest[g*COORD_W +: COORD_W]),
      .loc (locReg[g*COORD_W +: COORD_W]),
      .dir (axisDir[g])
    );
  end

  assign nextHdr = {inDest, axisDir[1], axisDir[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outHdr     <= '0;
      outPayload <= '0;
    end else if (strb.loadOut) begin
      outHdr     <= nextHdr;
      outPayload <= inPayload;
    end
  end

endmodule

// File: rtl/torus_hdr_ctl.sv
module torus_hdr_ctl
  import torus_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       locLoad,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output ctlStrobe_t strb
);

  logic locValid;

  assign inReady      = locValid && (!outValid || outReady);
  assign strb.capLoc  = locLoad && !locValid;
  assign strb.loadOut = inValid && inReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (strb.capLoc) begin
        locValid <= 1'b1;
      end
      if (strb.loadOut) begin
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/torus_hdr_builder.sv
module torus_hdr_builder
  import torus_hdr_pkg::*;
#(
  parameter int COORD_W   = 2,
  parameter int PAYLOAD_W = 32,
  localparam int LOC_W = 2 * COORD_W,
  localparam int HDR_W = LOC_W + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 locLoad,
  input  logic [LOC_W-1:0]     locIn,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [LOC_W-1:0]     inDest,
  input  logic [PAYLOAD_W-1:0] inPayload,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [HDR_W-1:0]     outHdr,
  output logic [PAYLOAD_W-1:0] outPayload
);

  ctlStrobe_t strb;

  torus_hdr_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .locLoad  (locLoad),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  torus_hdr_dp #(.COORD_W(COORD_W), .PAYLOAD_W(PAYLOAD_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .locIn      (locIn),
    .inDest     (inDest),
    .inPayload  (inPayload),
    .outHdr     (outHdr),
    .outPayload (outPayload)
  );

endmodule

// File: rtl/torus_hdr_builder_chk.sv
module torus_hdr_builder_chk #(
  parameter int COORD_W   = 2,
  parameter int PAYLOAD_W = 32,
  localparam int LOC_W = 2 * COORD_W,
  localparam int HDR_W = LOC_W + 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inValid,
  input logic                 inReady,
  input logic [LOC_W-1:0]     inDest,
  input logic [PAYLOAD_W-1:0] inPayload,
  input logic                 outValid,
  input logic                 outReady,
  input logic [HDR_W-1:0]     outHdr,
  input logic [PAYLOAD_W-1:0] outPayload
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outHdr) && $stable(outPayload)); // R9

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |-> !inReady); // R9

  AST_ACCEPT_NEXT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> outValid); // R8

  AST_PAYLOAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> outPayload == $past(inPayload)); // R7

  AST_DEST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> outHdr[HDR_W-1:4] == $past(inDest)); // R6

  AST_XDIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outHdr[3:2] == 2'b01) || (outHdr[3:2] == 2'b10)); // R4

  AST_YDIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outHdr[1:0] == 2'b01) || (outHdr[1:0] == 2'b10)); // R5

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outReady && !(inValid && inReady) |=> !outValid); // R10

endmodule

bind torus_hdr_builder torus_hdr_builder_chk #(.COORD_W(COORD_W), .PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .inReady    (inReady),
  .inDest     (inDest),
  .inPayload  (inPayload),
  .outValid   (outValid),
  .outReady   (outReady),
  .outHdr     (outHdr),
  .outPayload (outPayload)
);

// File: tb/torus_hdr_builder_tb.sv
`timescale 1ns/1ps
module torus_hdr_builder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        locLoad = 1'b0;
  logic [3:0]  locIn = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [3:0]  inDest = '0;
  logic [31:0] inPayload = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [7:0]  outHdr;
  logic [31:0] outPayload;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  torus_hdr_builder u_dut (
    .clk(clk), .rst_n(rst_n), .locLoad(locLoad), .locIn(locIn),
    .inValid(inValid), .inReady(inReady), .inDest(inDest), .inPayload(inPayload),
    .outValid(outValid), .outReady(outReady), .outHdr(outHdr), .outPayload(outPayload)
  );

  // Reference: shortest-way code from the signed difference table
  function automatic logic [1:0] refDir(int d);
    if (d == 1 || d == 2 || d == -3) return 2'b01;
    return 2'b10;
  endfunction

  // Behavioural reference state
  logic [3:0]  mLoc = '0;
  logic        mLocValid = 1'b0;
  logic        mOutValid = 1'b0;
  logic [7:0]  mOutHdr = '0;
  logic [31:0] mOutPay = '0;

  function automatic logic mInReady();
    return mLocValid && (!mOutValid || outReady);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mLoc <= '0; mLocValid <= 1'b0; mOutValid <= 1'b0; mOutHdr <= '0; mOutPay <= '0;
    end else begin
      if (locLoad && !mLocValid) begin
        mLoc <= locIn; mLocValid <= 1'b1;
      end
      if (inValid && mInReady()) begin
        mOutValid <= 1'b1;
        mOutHdr   <= {inDest,
                      refDir(int'(inDest[3:2]) - int'(mLoc[3:2])),
                      refDir(int'(inDest[1:0]) - int'(mLoc[1:0]))};
        mOutPay   <= inPayload;
      end else if (outReady) begin
        mOutValid <= 1'b0;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check("R9 inReady", 32'(inReady), 32'(mInReady()));
      check("R8 outValid", 32'(outValid), 32'(mOutValid));
      if (mOutValid) begin
        check("R6 dest field", 32'(outHdr[7:4]), 32'(mOutHdr[7:4]));
        check("R4 X direction", 32'(outHdr[3:2]), 32'(mOutHdr[3:2]));
        check("R5 Y direction", 32'(outHdr[1:0]), 32'(mOutHdr[1:0]));
        check("R7 payload", outPayload, mOutPay);
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; inValid = 1'b0; locLoad = 1'b0; outReady = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic loadLoc(logic [3:0] l);
    @(negedge clk);
    locLoad = 1'b1; locIn = l;
    @(negedge clk);
    locLoad = 1'b0;
    #1;
    check("R2 ready after load", 32'(inReady), 32'd1);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state and no acceptance before location load
    doReset();
    @(negedge clk);
    inValid = 1'b1; inDest = 4'h5; outReady = 1'b1;
    #1;
    check("R1 inReady before load", 32'(inReady), 32'd0);
    check("R1 outValid after reset", 32'(outValid), 32'd0);
    @(negedge clk);
    #1;
    check("R1 no accept before load", 32'(outValid), 32'd0);
    inValid = 1'b0;

    // R4 R5 R6 R7 R8 R10: all 256 location/destination pairs, back to back
    for (int l = 0; l < 16; l++) begin
      doReset();
      loadLoc(4'(l));
      for (int d = 0; d < 16; d++) begin
        @(negedge clk);
        inValid = 1'b1; outReady = 1'b1; inDest = 4'(d); inPayload = $urandom;
        #1;
        check("R10 ready while streaming", 32'(inReady), 32'd1);
      end
      @(negedge clk);
      inValid = 1'b0;
      #1;
      check("R10 last packet shown", 32'(outValid), 32'd1);
      @(negedge clk);
      #1;
      check("R10 drained", 32'(outValid), 32'd0);
    end

    // R3: second location load is ignored
    doReset();
    loadLoc(4'b0101);          // (1,1)
    @(negedge clk);
    locLoad = 1'b1; locIn = 4'b1111;   // (3,3) must not take effect
    @(negedge clk);
    locLoad = 1'b0;
    inValid = 1'b1; outReady = 1'b1; inDest = 4'b1001; inPayload = 32'hCAFE0001; // dest (2,1)
    @(negedge clk);
    inValid = 1'b0;
    #1;
    check("R3 header after ignored reload", 32'(outHdr), 32'b1001_01_10);

    // R9: random stalls and offers
    doReset();
    loadLoc(4'b1110);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      inValid = 1'($urandom); outReady = 1'($urandom); inDest = 4'($urandom); inPayload = $urandom;
    end
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule